// File: doc/BRIEF.md
# Clock Failure Watch Register

This block is an 8-bit control and status register for the clock system of a chip. It collects failure reports from two outside monitors. One watches the external oscillator and the other watches PLL lock. Each monitor has an arm bit and a sticky flag. A flag is set only while its monitor is armed. Software clears a flag by writing a one to it. When any armed monitor has its flag set, the block raises a non-maskable interrupt request.

The arm bits are guarded. A write changes them only inside a short window that opens after an unlock pulse from the chip's protection logic. The write that uses the window also closes it. Once the oscillator arm bit is set, it stays set until reset, whatever is written later. The flags need no window. The monitors that detect failures sit outside this block and report through single-cycle event inputs.

Top module: `cfd_ctrl_reg`

## Requirements
- R1: After reset, every bit of `rd_data` reads 0 and `nmi_req` is low.
- R2: Bits 7 to 4 always read 0. Values written to them have no effect, with or without an open window.
- R3: Bit 1 (oscillator flag) is set on the clock edge where `osc_fail_evt` is high while bit 0 (oscillator arm) is 1. An event while bit 0 is 0 leaves the flag at 0.
- R4: Bit 3 (PLL flag) is set on the clock edge where `pll_unlock_evt` is high while bit 2 (PLL arm) is 1. An event while bit 2 is 0 leaves the flag unchanged.
- R5: A write with bit 3 or bit 1 at 1 clears that flag. A 0 in those positions leaves the flag unchanged. No protection window is needed.
- R6: If a failure event and a clearing write reach the same flag in one cycle, the flag ends up set.
- R7: Bits 2 and 0 change only on a write inside the protection window. The window opens on the edge after the edge that samples `unlock_pulse`, and it covers WIN_CYCLES (default 4) consecutive edges. A write at the next edge, or with no unlock at all, leaves both bits unchanged.
- R8: A write accepted inside the window closes it, so a second write at the very next edge cannot change bits 2 and 0.
- R9: Once bit 0 is 1, a write of 0 to it inside the window leaves it at 1. Bit 2 takes the written value, so it can be cleared.
- R10: `nmi_req` is high from the edge after (bit 3 AND bit 2) OR (bit 1 AND bit 0) becomes true, and it goes low one edge after both terms are false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| osc_fail_evt | input | 1 | Oscillator failure report from the monitor |
| pll_unlock_evt | input | 1 | PLL lock-loss report from the monitor |
| unlock_pulse | input | 1 | Opens the protection window |
| nmi_req | output | 1 | Registered non-maskable interrupt request |

## Verification
The hardest states to reach are the edges of the protection window. The bench lands one write on the last edge inside the window and another on the first edge after it closes. It also places a second write on the edge right after an accepted one. Both cases need the unlock pulse and the write strobe timed to the exact cycle, so each scenario task drives the pulse and then counts a set number of idle cycles before the write. A second hard case is the cycle where an event and a clearing write arrive together. The bench raises the event input and the write strobe on the same falling edge.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_MON = 2;
  // monitor i owns arm bit 2*i and flag bit 2*i+1
  localparam int MON_OSC = 0;
  localparam int MON_PLL = 1;
  localparam int USED_W  = 2 * NUM_MON;

  function automatic int arm_pos(input int idx);
    return 2 * idx;
  endfunction

  function automatic int flag_pos(input int idx);
    return 2 * idx + 1;
  endfunction
endpackage

// File: rtl/cfd_guard_window.sv
module cfd_guard_window #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic unlock,
  input  logic wr_en,
  output logic open
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  assign open = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (unlock) begin
      cnt_q <= CNT_LOAD;
    end else if (open && wr_en) begin
      cnt_q <= '0;
    end else if (open) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  win_len_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LOAD);

  // R8
  win_close_chk: assert property (@(posedge clk) disable iff (rst)
    (open && wr_en && !unlock) |=> !open);

  // R7
  win_open_chk: assert property (@(posedge clk) disable iff (rst)
    unlock |=> open);
endmodule

// File: rtl/cfd_flag_cell.sv
module cfd_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic armed,
  input  logic clr,
  output logic q
);
  logic set_now;
  assign set_now = evt && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (set_now) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end

  // R6
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && armed) |=> q);

  // R3
  flag_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!q && !(evt && armed)) |=> !q);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
endmodule

// File: rtl/cfd_arm_cell.sv
module cfd_arm_cell #(
  parameter bit STICKY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_ok,
  input  logic wr_bit,
  output logic q
);
  logic q_nxt;

  generate
    if (STICKY) begin : g_sticky
      assign q_nxt = q | wr_bit;
    end else begin : g_plain
      assign q_nxt = wr_bit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (wr_ok) begin
      q <= q_nxt;
    end
  end

  // R7
  arm_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(q));

  generate
    if (STICKY) begin : g_sticky_chk
      // R9
      arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        q |=> q);
    end
  endgenerate
endmodule

// File: rtl/cfd_ctrl_reg.sv
module cfd_ctrl_reg
  import cfd_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             osc_fail_evt,
  input  logic             pll_unlock_evt,
  input  logic             unlock_pulse,
  output logic             nmi_req
);
  logic               win_open;
  logic               arm_wr_ok;
  logic [NUM_MON-1:0] evt_vec;
  logic [NUM_MON-1:0] arm_q;
  logic [NUM_MON-1:0] flag_q;
  logic               nmi_q;

  assign evt_vec[MON_OSC] = osc_fail_evt;
  assign evt_vec[MON_PLL] = pll_unlock_evt;
  assign arm_wr_ok        = wr_en && win_open;

  cfd_guard_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk    (clk),
    .rst    (rst),
    .unlock (unlock_pulse),
    .wr_en  (wr_en),
    .open   (win_open)
  );

  generate
    for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
      localparam int AP = arm_pos(i);
      localparam int FP = flag_pos(i);

      cfd_arm_cell #(.STICKY(i == MON_OSC)) u_arm (
        .clk    (clk),
        .rst    (rst),
        .wr_ok  (arm_wr_ok),
        .wr_bit (wr_data[AP]),
        .q      (arm_q[i])
      );

      cfd_flag_cell u_flag (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_vec[i]),
        .armed (arm_q[i]),
        .clr   (wr_en && wr_data[FP]),
        .q     (flag_q[i])
      );

      assign rd_data[AP] = arm_q[i];
      assign rd_data[FP] = flag_q[i];
    end
  endgenerate

  assign rd_data[REG_W-1:USED_W] = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= |(flag_q & arm_q);
    end
  end

  assign nmi_req = nmi_q;

  // R10
  nmi_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & arm_q)) |=> nmi_req);

  // R10
  nmi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & arm_q)) |=> !nmi_req);

  // R2
  always_comb begin
    if (!rst) begin
      reserved_zero_chk: assert (rd_data[REG_W-1:USED_W] == '0);
    end
  end
endmodule

// File: tb/cfd_ctrl_reg_bench.sv
module cfd_ctrl_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       osc_fail_evt = 1'b0;
  logic       pll_unlock_evt = 1'b0;
  logic       unlock_pulse = 1'b0;
  logic       nmi_req;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cfd_ctrl_reg u_cfd_ctrl_reg (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .osc_fail_evt   (osc_fail_evt),
    .pll_unlock_evt (pll_unlock_evt),
    .unlock_pulse   (unlock_pulse),
    .nmi_req        (nmi_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic guarded_write(input int gap, input logic [7:0] d);
    unlock_pulse = 1'b1;
    @(negedge clk);
    unlock_pulse = 1'b0;
    idle(gap);
    write_reg(d);
  endtask

  task automatic pulse_osc();
    osc_fail_evt = 1'b1;
    @(negedge clk);
    osc_fail_evt = 1'b0;
  endtask

  task automatic pulse_pll();
    pll_unlock_evt = 1'b1;
    @(negedge clk);
    pll_unlock_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 nmi", {7'd0, nmi_req}, 8'h00);
  endtask

  task automatic t_reserved();
    write_reg(8'hF0);
    chk("R2 plain", rd_data, 8'h00);
    guarded_write(0, 8'hF0);
    chk("R2 window", rd_data, 8'h00);
  endtask

  task automatic t_unarmed_events();
    pulse_osc();
    pulse_pll();
    chk("R3 R4 unarmed", rd_data, 8'h00);
  endtask

  task automatic t_guard();
    write_reg(8'h05);
    chk("R7 no unlock", rd_data, 8'h00);
    guarded_write(4, 8'h05);
    chk("R7 late write", rd_data, 8'h00);
    guarded_write(3, 8'h04);
    chk("R7 last edge", rd_data, 8'h04);
  endtask

  task automatic t_close();
    guarded_write(0, 8'h05);
    chk("R7 first edge", rd_data, 8'h05);
    write_reg(8'h00);
    chk("R8 closed", rd_data, 8'h05);
  endtask

  task automatic t_flags();
    pulse_osc();
    chk("R3 set", rd_data, 8'h07);
    idle(1);
    chk("R10 rise", {7'd0, nmi_req}, 8'h01);
    pulse_pll();
    chk("R4 set", rd_data, 8'h0F);
    write_reg(8'h02);
    chk("R5 clr osc", rd_data, 8'h0D);
    idle(1);
    chk("R10 held", {7'd0, nmi_req}, 8'h01);
    write_reg(8'h08);
    chk("R5 clr pll", rd_data, 8'h05);
    chk("R10 lag", {7'd0, nmi_req}, 8'h01);
    idle(1);
    chk("R10 fall", {7'd0, nmi_req}, 8'h00);
  endtask

  task automatic t_race();
    osc_fail_evt = 1'b1;
    wr_en = 1'b1; wr_data = 8'h02;
    @(negedge clk);
    osc_fail_evt = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00;
    chk("R6 set wins", rd_data, 8'h07);
    write_reg(8'h02);
    chk("R5 clr after race", rd_data, 8'h05);
  endtask

  task automatic t_sticky();
    pulse_pll();
    chk("R4 set again", rd_data, 8'h0D);
    guarded_write(0, 8'h01);
    chk("R9 pll disarm", rd_data, 8'h09);
    idle(1);
    chk("R10 flag unarmed", {7'd0, nmi_req}, 8'h00);
    pulse_pll();
    chk("R4 no change unarmed", rd_data, 8'h09);
    write_reg(8'h08);
    chk("R5 clr pll", rd_data, 8'h01);
    guarded_write(1, 8'h00);
    chk("R9 osc sticky", rd_data, 8'h01);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_reserved();
        t_unarmed_events();
        t_guard();
        t_close();
        t_flags();
        t_race();
        t_sticky();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule